// File: doc/BRIEF.md
# Display Power-Up Command Sequencer

This block brings a serial display controller out of reset without processor help. After one start pulse it reads a fixed initialization script from an internal table and sends it over a 4-wire SPI link: serial clock, serial data out, an active-low chip select, and a data/command select line. Each script entry is one of two kinds. A command entry is an opcode followed by up to fifteen parameter bytes. A delay entry is the reserved opcode 0xFF followed by a millisecond count. A delay entry sends nothing on the link.

When the script ends, the block appends a full-screen window setup. This covers the column range, the row range and a memory-write opener. Only then does it raise `done`. Millisecond timing comes from a prescaler sized by the parameter `ClksPerMs`. The serial clock half period is `ClkDiv` system clocks.

Top module: `panel_init_seq`

## Requirements
- R1: Out of reset, csN, dataNotCmd and sclk are 1, and busy and done are 0.
- R2: busy rises the cycle after an accepted start and stays high until done rises. done stays high until the next accepted start. busy and done are never high together.
- R3: A startPulse received while busy has no effect. Exactly 34 bytes go out per run, in order, with no restart.
- R4: Every byte has its own chip-select frame with exactly 8 rising sclk edges. sclk is high whenever csN is high (clock idles high). Data is sampled on the rising edge, most significant bit first.
- R5: A command (opcode) byte is sent with dataNotCmd = 0 and a parameter byte with dataNotCmd = 1. dataNotCmd does not change while csN is low.
- R6: A delay entry (opcode 0xFF, value = milliseconds) causes no bus activity. It holds chip select high for at least value*ClksPerMs and at most value*ClksPerMs + ClkDiv + 8 clock cycles between the neighbouring frames.
- R7: The script order is as follows:
  - 0x01 (software reset), then a 20 ms wait;
  - 0x11 (sleep exit), then a 120 ms wait;
  - 0x3A with parameter 0x55;
  - 0x36 with parameter 0x08;
  - the gamma entry 0xE0;
  - 0x29 (display on), then a 20 ms wait.
- R8: The gamma entry 0xE0 carries the maximum of 15 parameters, with values 0x20 + 2*k for k = 0..14.
- R9: After the script, the window setup is sent, and done rises only after its last byte. The setup is:
  - 0x2A with parameters {0x00, 0x00, (PanelWidth-1) high byte, low byte};
  - 0x2B with parameters {0x00, 0x00, (PanelHeight-1) high byte, low byte};
  - 0x2C with no parameters.
- R10: Within a frame, successive rising sclk edges are exactly 2*ClkDiv system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Start request, acted on only when not busy |
| busy | output | 1 | Script replay in progress |
| done | output | 1 | Script and window setup complete |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out, MSB first |
| csN | output | 1 | Chip select, active low, one frame per byte |
| dataNotCmd | output | 1 | 0 for opcode bytes, 1 for parameter bytes |

## Verification
The following are checked on every cycle:
- The clock idles high while deselected.
- The data/command level holds steady inside a frame.
- No byte is loaded while a frame is still shifting.
- The millisecond counter only counts down.
- busy and done never overlap.
- A start pulse during a run does not drop busy.
- done appears only at the end of the table.

The bench scenarios cover what no single-cycle property can show:
- the exact byte and level stream of the script and the window setup;
- the widths of the delay gaps measured at the pins;
- the serial clock period;
- the survival of the sequence under random stray start pulses.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic       loadByte;
    logic [7:0] byteVal;
    logic       byteDc;
    logic       loadMs;
    logic [7:0] msVal;
  } seqStrobe_t;

  localparam logic [7:0] DelayOp = 8'hFF;
  localparam int ScriptBytes = 35;  // init script portion of the table
  localparam int TotalBytes  = 49;  // script plus window setup
  localparam int GammaFirst  = 16;
  localparam int GammaLast   = 30;

  // Table layout: header byte (opcode or 0xFF), then count byte
  // (parameter count or milliseconds), then the parameters.
  function automatic logic [7:0] romByte(input int idx, input int w, input int h);
    logic [15:0] xEnd;
    logic [15:0] yEnd;
    xEnd = 16'(w - 1);
    yEnd = 16'(h - 1);
    if (idx >= GammaFirst && idx <= GammaLast)
      return 8'(32'h20 + 2 * (idx - GammaFirst));
    case (idx)
      0:  return 8'h01;
      1:  return 8'd0;
      2:  return DelayOp;
      3:  return 8'd20;
      4:  return 8'h11;
      5:  return 8'd0;
      6:  return DelayOp;
      7:  return 8'd120;
      8:  return 8'h3A;
      9:  return 8'd1;
      10: return 8'h55;
      11: return 8'h36;
      12: return 8'd1;
      13: return 8'h08;
      14: return 8'hE0;
      15: return 8'd15;
      31: return 8'h29;
      32: return 8'd0;
      33: return DelayOp;
      34: return 8'd20;
      35: return 8'h2A;
      36: return 8'd4;
      39: return xEnd[15:8];
      40: return xEnd[7:0];
      41: return 8'h2B;
      42: return 8'd4;
      45: return yEnd[15:8];
      46: return yEnd[7:0];
      47: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int PanelWidth  = 240,
  parameter int PanelHeight = 320
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       shDone,
  input  logic       timerZero,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int PtrW = $clog2(TotalBytes + 1);

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_XFER, S_DELAY, S_FIN} state_t;

  state_t          state, nState;
  logic [PtrW-1:0] ptr, nPtr;
  logic [3:0]      remain, nRemain;
  logic [7:0]      curByte, nextByte;
  logic            atEnd;

  assign curByte  = romByte(int'(ptr), PanelWidth, PanelHeight);
  assign nextByte = romByte(int'(ptr) + 1, PanelWidth, PanelHeight);
  assign atEnd    = (ptr == PtrW'(TotalBytes));

  always_comb begin
    strb    = '0;
    nState  = state;
    nPtr    = ptr;
    nRemain = remain;
    case (state)
      S_IDLE, S_FIN: begin
        if (startPulse) begin
          nState = S_HEAD;
          nPtr   = '0;
        end
      end
      S_HEAD: begin
        nPtr = ptr + PtrW'(2);
        if (curByte == DelayOp) begin
          strb.loadMs = 1'b1;
          strb.msVal  = nextByte;
          nState      = S_DELAY;
        end else begin
          strb.loadByte = 1'b1;
          strb.byteVal  = curByte;
          strb.byteDc   = 1'b0;
          nRemain       = nextByte[3:0];
          nState        = S_XFER;
        end
      end
      S_XFER: begin
        if (shDone) begin
          if (remain != 4'd0) begin
            strb.loadByte = 1'b1;
            strb.byteVal  = curByte;
            strb.byteDc   = 1'b1;
            nPtr          = ptr + PtrW'(1);
            nRemain       = remain - 4'd1;
          end else begin
            nState = atEnd ? S_FIN : S_HEAD;
          end
        end
      end
      S_DELAY: begin
        if (timerZero) nState = atEnd ? S_FIN : S_HEAD;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ptr    <= '0;
      remain <= '0;
    end else begin
      state  <= nState;
      ptr    <= nPtr;
      remain <= nRemain;
    end
  end

  assign busy = (state == S_HEAD) || (state == S_XFER) || (state == S_DELAY);
  assign done = (state == S_FIN);

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(busy && done)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN) (busy && startPulse) |=> (busy || done)); // R3
  AST_DELAY_SILENT: assert property (@(posedge clk) disable iff (!rstN) (state == S_DELAY) |-> !strb.loadByte); // R6
  AST_FIN_AT_END: assert property (@(posedge clk) disable iff (!rstN) $rose(done) |-> atEnd); // R9

endmodule

// File: rtl/panel_seq_dp.sv
module panel_seq_dp
  import panel_seq_pkg::*;
#(
  parameter int ClkDiv    = 4,
  parameter int ClksPerMs = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       shDone,
  output logic       timerZero,
  output logic       sclk,
  output logic       mosi,
  output logic       csN,
  output logic       dataNotCmd
);
  localparam int DivW     = $clog2(ClkDiv) + 1;
  localparam int PreW     = $clog2(ClksPerMs) + 1;
  localparam int LastStep = 18;  // setup, 16 clock halves, hold, deselect

  logic            active;
  logic [DivW-1:0] divCnt;
  logic [4:0]      step, nStep;
  logic [7:0]      shReg;
  logic            halfEnd;

  assign halfEnd = active && (divCnt == DivW'(ClkDiv - 1));
  assign nStep   = step + 5'd1;
  assign mosi    = shReg[7];

  // byte shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      divCnt     <= '0;
      step       <= '0;
      shReg      <= '0;
      csN        <= 1'b1;
      dataNotCmd <= 1'b1;
      sclk       <= 1'b1;
      shDone     <= 1'b0;
    end else begin
      shDone <= 1'b0;
      if (strb.loadByte) begin
        active     <= 1'b1;
        divCnt     <= '0;
        step       <= '0;
        shReg      <= strb.byteVal;
        csN        <= 1'b0;
        dataNotCmd <= strb.byteDc;
        sclk       <= 1'b1;
      end else if (active) begin
        if (halfEnd) begin
          divCnt <= '0;
          step   <= nStep;
          sclk   <= !(nStep >= 5'd1 && nStep <= 5'd16 && nStep[0]);
          if (!step[0] && step >= 5'd2 && step <= 5'd14) shReg <= {shReg[6:0], 1'b0};
          if (nStep == 5'(LastStep)) begin
            csN        <= 1'b1;
            dataNotCmd <= 1'b1;
          end
          if (step == 5'(LastStep)) begin
            active <= 1'b0;
            shDone <= 1'b1;
          end
        end else begin
          divCnt <= divCnt + DivW'(1);
        end
      end
    end
  end

  // millisecond timer
  logic [7:0]      msLeft;
  logic [PreW-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msLeft <= '0;
      preCnt <= '0;
    end else if (strb.loadMs) begin
      msLeft <= strb.msVal;
      preCnt <= '0;
    end else if (msLeft != 8'd0) begin
      if (preCnt == PreW'(ClksPerMs - 1)) begin
        preCnt <= '0;
        msLeft <= msLeft - 8'd1;
      end else begin
        preCnt <= preCnt + PreW'(1);
      end
    end
  end

  assign timerZero = (msLeft == 8'd0);

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN) csN |-> sclk); // R4
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN) strb.loadByte |-> !active); // R4
  AST_DC_STABLE: assert property (@(posedge clk) disable iff (!rstN) (!csN && $past(!csN)) |-> $stable(dataNotCmd)); // R5
  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rstN) (!strb.loadMs && msLeft != 8'd0) |=> (msLeft <= $past(msLeft))); // R6

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_seq_pkg::*;
#(
  parameter int ClkDiv      = 4,
  parameter int ClksPerMs   = 1000,
  parameter int PanelWidth  = 240,
  parameter int PanelHeight = 320
) (
  input  logic clk,
  input  logic rstN,
  input  logic startPulse,
  output logic busy,
  output logic done,
  output logic sclk,
  output logic mosi,
  output logic csN,
  output logic dataNotCmd
);
  seqStrobe_t strb;
  logic       shDone;
  logic       timerZero;

  panel_seq_ctrl #(.PanelWidth(PanelWidth), .PanelHeight(PanelHeight)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .shDone(shDone),
    .timerZero(timerZero), .strb(strb), .busy(busy), .done(done)
  );

  panel_seq_dp #(.ClkDiv(ClkDiv), .ClksPerMs(ClksPerMs)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .shDone(shDone), .timerZero(timerZero),
    .sclk(sclk), .mosi(mosi), .csN(csN), .dataNotCmd(dataNotCmd)
  );

endmodule

// File: tb/panel_init_seq_tb.sv
`timescale 1ns/100ps
module panel_init_seq_tb_top;
  localparam int CLK_DIV = 2;
  localparam int CPM     = 20;
  localparam int W       = 240;
  localparam int H       = 320;
  localparam int NBYTES  = 34;
  localparam real TCLK   = 5.0;

  logic clk = 0, rstN = 0, startPulse = 0;
  logic busy, done, sclk, mosi, csN, dataNotCmd;
  int checks = 0, errors = 0;
  bit hung = 0;

  always #2.5 clk = ~clk;

  panel_init_seq #(.ClkDiv(CLK_DIV), .ClksPerMs(CPM), .PanelWidth(W), .PanelHeight(H)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .csN(csN), .dataNotCmd(dataNotCmd)
  );

  // pin monitor
  real        fallT[64], riseT[64];
  logic [7:0] rxB[64];
  logic       rxDc[64], rxPerOk[64], rxSclkHi[64];
  int         rxBits[64];
  int         rxN = 0, bitCnt = 0;
  logic [7:0] shIn;
  logic       dcSeen, perOk;
  real        lastRise, curFall, doneT;

  always @(negedge csN) if (rstN) begin
    curFall = $realtime; bitCnt = 0; shIn = 0; perOk = 1;
  end
  always @(posedge sclk) if (rstN && !csN) begin
    if (bitCnt == 0) dcSeen = dataNotCmd;
    else if (($realtime - lastRise) > 2*CLK_DIV*TCLK + 0.1 || ($realtime - lastRise) < 2*CLK_DIV*TCLK - 0.1) perOk = 0;
    lastRise = $realtime;
    shIn = {shIn[6:0], mosi};
    bitCnt++;
  end
  always @(posedge csN) if (rstN) begin
    if (rxN < 64) begin
      fallT[rxN] = curFall; riseT[rxN] = $realtime; rxB[rxN] = shIn; rxDc[rxN] = dcSeen;
      rxBits[rxN] = bitCnt; rxPerOk[rxN] = perOk; rxSclkHi[rxN] = sclk;
    end
    rxN++;
  end
  always @(posedge done) doneT = $realtime;

  // expected stream {dc, byte} from R7, R8, R9
  function automatic logic [8:0] expTx(int i);
    logic [15:0] xe, ye;
    xe = 16'(W - 1); ye = 16'(H - 1);
    if (i >= 7 && i <= 21) return {1'b1, 8'(32'h20 + 2*(i-7))};
    case (i)
      0: return {1'b0, 8'h01};  1: return {1'b0, 8'h11};
      2: return {1'b0, 8'h3A};  3: return {1'b1, 8'h55};
      4: return {1'b0, 8'h36};  5: return {1'b1, 8'h08};
      6: return {1'b0, 8'hE0};  22: return {1'b0, 8'h29};
      23: return {1'b0, 8'h2A}; 26: return {1'b1, xe[15:8]}; 27: return {1'b1, xe[7:0]};
      28: return {1'b0, 8'h2B}; 31: return {1'b1, ye[15:8]}; 32: return {1'b1, ye[7:0]};
      33: return {1'b0, 8'h2C};
      default: return {1'b1, 8'h00};
    endcase
  endfunction

  // milliseconds of delay expected before byte i
  function automatic int expMs(int i);
    case (i)
      1: return 20; 2: return 120; 23: return 20;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic runOnce(input int strayPct);
    int wd;
    int gap;
    int lo;
    logic [8:0] e;
    rxN = 0;
    repeat (1 + $urandom_range(0, 9)) @(negedge clk);
    startPulse = 1; @(negedge clk); startPulse = 0;
    chk(busy === 1'b1 && done === 1'b0, "R2", "busy after start", busy, 1);
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk); wd++;
      if (busy && $urandom_range(0, 99) < strayPct) begin
        startPulse = 1; @(negedge clk); startPulse = 0; wd++;   // R3 stray start
      end
    end
    if (!done) begin
      hung = 1;
      chk(0, "R2", "watchdog expired waiting for done", 0, 1);
      return;
    end
    chk(busy === 1'b0, "R2", "busy low with done", busy, 0);
    chk(rxN == NBYTES, "R3", "frame count", rxN, NBYTES);
    for (int i = 0; i < NBYTES && i < rxN; i++) begin
      e = expTx(i);
      chk(rxB[i] == e[7:0], (i >= 7 && i <= 21) ? "R8" : (i >= 23 ? "R9" : "R7"), $sformatf("byte %0d value", i), rxB[i], e[7:0]);
      chk(rxDc[i] == e[8], "R5", $sformatf("byte %0d data/command level", i), rxDc[i], e[8]);
      chk(rxBits[i] == 8 && rxSclkHi[i], "R4", $sformatf("byte %0d rising edges", i), rxBits[i], 8);
      chk(rxPerOk[i], "R10", $sformatf("byte %0d sclk period", i), rxPerOk[i], 1);
      if (i > 0) begin
        gap = int'((fallT[i] - riseT[i-1]) / TCLK);
        lo  = expMs(i) * CPM + CLK_DIV;
        chk(gap >= lo && gap <= lo + 8, "R6", $sformatf("gap before byte %0d", i), gap, lo);
      end
    end
    chk(rxN > 0 && doneT > riseT[NBYTES-1], "R9", "done after last window byte", int'(doneT), int'(riseT[NBYTES-1]));
    repeat (10) @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R2", "done held while idle", done, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(csN === 1'b1 && dataNotCmd === 1'b1 && sclk === 1'b1, "R1", "pins in reset", {csN, dataNotCmd, sclk}, 7);
    chk(busy === 1'b0 && done === 1'b0, "R1", "status in reset", {busy, done}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(csN === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "idle after reset", {csN, busy, done}, 4);
    runOnce(0);
    if (!hung) runOnce(2);
    if (!hung) runOnce(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule